// File: doc/BRIEF.md
# Row-Sliding 3x3 Convolution Engine

This block computes a 3x3 convolution one output row at a time. Input rows arrive whole over a ready/valid port and go into three rotating row banks. The three most recent rows form the window: the oldest is the top row and the newest is the bottom row. When a row is accepted with the compute flag set, the 3x3 weight matrix that came with it is latched. That matrix then slides across the window one column per clock. Nine multipliers and an adder tree produce one complete 3x3 dot product every cycle.

Each column's dot product is added into a partial-sum row memory. For the first input channel the starting value is zero, or a configured bias. For later channels the starting value is the partial sum already stored, which is fed back from the memory. When the final channel's sweep finishes, the completed row is streamed out one column per handshake. Several channels can be accumulated into one output row by pushing each channel's rows in turn. Rows pushed without the compute flag only fill the window.

Control is a three-state machine:
- IDLE: ready for a row. An accepted computing row moves it to SWEEP. A non-computing row keeps it in IDLE.
- SWEEP: one column per cycle. At the last column it moves to EMIT if the last-channel flag was latched, otherwise back to IDLE.
- EMIT: presents output columns. After the last column is taken it returns to IDLE.

Top module: `rowconv3_engine`

## Requirements
- R1: After reset the engine is in IDLE, with `in_ready` high and `out_valid` low.
- R2: A row accepted with `in_compute` low only enters the window. The engine stays in IDLE, with `in_ready` still high at the next cycle, and produces no output. Stored partial sums are left unchanged.
- R3: Each accepted row overwrites the oldest bank.
  - The window rows are ordered oldest (top, r=0) to newest (bottom, r=2).
  - Row column j sits at `in_row[j*DW +: DW]`.
  - Weight tap (r,c) sits at `in_wgt[(3r+c)*WW +: WW]`, where c=0 is the left tap.
- R4: Output column x equals the sum over r and c of w(r,c) times row_r[x+c-1]. Any column index outside 0..width-1 reads as zero, whatever the row holds there.
- R5: On a computing row with `in_first` high, each column starts from `cfg_bias` if `cfg_bias_en` is high, and from zero otherwise. With `in_first` low, each column adds onto the stored partial sum.
- R6: Emission depends on `in_last` of the computing row.
  - If `in_last` is high, exactly `width` output beats follow the sweep, column 0 first, with `out_last` high only on the final beat. The engine then returns to IDLE.
  - If `in_last` is low, no output is produced.
- R7: A computing row keeps `in_ready` low for exactly `width` cycles of sweep before the engine returns to IDLE or starts emitting.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R9: All data, weights, bias and outputs are signed two's complement. `cfg_width` must lie in 1..MAX_W when a row is accepted.
- R10: The weights, width, bias and flags are latched at row acceptance. Changing these inputs during SWEEP or EMIT has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Engine accepts a row (IDLE) |
| in_row | input | MAX_W*DW | Whole input row, column j at j*DW |
| in_wgt | input | 9*WW | 3x3 weights, tap (r,c) at (3r+c)*WW |
| in_compute | input | 1 | Sweep the window after storing this row |
| in_first | input | 1 | First input channel: start from zero or bias |
| in_last | input | 1 | Last input channel: emit the row after the sweep |
| cfg_width | input | $clog2(MAX_W+1) | Active row/output width |
| cfg_bias_en | input | 1 | Use cfg_bias as the first-channel start value |
| cfg_bias | input | AW | Signed bias value |
| out_valid | output | 1 | Output column available (EMIT) |
| out_ready | input | 1 | Consumer takes the output column |
| out_data | output | AW | Signed accumulated output column |
| out_last | output | 1 | Final column of the row |

## Verification
The assertions rely on the following about the inputs:
- `cfg_width` is in range whenever a row is accepted.
- The first computing row after reset, and the first of each new output row, carries `in_first`, since the partial-sum memory is never cleared.
- The product sums stay inside the accumulator width.

The bench keeps within these limits by construction:
- It sweeps every width from 1 to MAX_W.
- It always opens an output row with a first-channel row.
- It uses 8-bit signed values with few enough channels that the 24-bit accumulator cannot wrap.

It also deliberately fills row columns beyond the active width with nonzero values, and scrambles the configuration inputs after each accepted row, so that padding and latching faults show up in the results.

// File: rtl/rowconv3_pkg.sv
package rowconv3_pkg;

    // Controller states of the row engine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_EMIT  = 2'd2
    } eng_state_t;

    // Number of window taps
    localparam int NTAPS = 9;

    // Map logical window row (0 = oldest) onto a physical bank
    function automatic logic [1:0] bank_slot(input logic [1:0] head, input int r);
        int s;
        s = int'(head) + r;
        if (s >= 3) s = s - 3;
        return 2'(s);
    endfunction

endpackage

// File: rtl/rc3_row_banks.sv
module rc3_row_banks
    import rowconv3_pkg::*;
#(
    parameter int DW    = 8,
    parameter int MAX_W = 16,
    localparam int CW   = (MAX_W > 1) ? $clog2(MAX_W) : 1,
    localparam int NW   = $clog2(MAX_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [MAX_W*DW-1:0] wr_row,
    input  logic [CW-1:0]       rd_col,
    input  logic [NW-1:0]       rd_width,
    output logic [NTAPS*DW-1:0] taps
);

    logic [MAX_W*DW-1:0] bank [3];
    logic [1:0]          head;     // bank holding the oldest row

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= 2'd0;
        end else if (wr_en) begin
            head <= (head == 2'd2) ? 2'd0 : head + 2'd1;
        end
    end

    // Only the oldest bank is overwritten; the other two keep their rows
    for (genvar b = 0; b < 3; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (wr_en && head == 2'(b)) begin
                bank[b] <= wr_row;
            end
        end
    end

    // Window fetch with zero padding outside the active width
    always_comb begin
        taps = '0;
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                int col_i;
                col_i = int'(rd_col) + c - 1;
                if (col_i >= 0 && col_i < int'(rd_width)) begin
                    taps[(3*r+c)*DW +: DW] = bank[bank_slot(head, r)][col_i*DW +: DW];
                end
            end
        end
    end

    // R3
    head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head != 2'd3);

endmodule

// File: rtl/rc3_mac9.sv
module rc3_mac9
    import rowconv3_pkg::*;
#(
    parameter int DW  = 8,
    parameter int WW  = 8,
    localparam int PW  = DW + WW,
    localparam int LEV = $clog2(NTAPS),
    localparam int LEAVES = 1 << LEV,
    localparam int SW  = PW + LEV
) (
    input  logic [NTAPS*DW-1:0] taps,
    input  logic [NTAPS*WW-1:0] wgts,
    output logic [SW-1:0]       sum
);

    for (genvar l = 0; l <= LEV; l++) begin : g_lvl
        logic signed [SW-1:0] v [LEAVES >> l];
        if (l == 0) begin : g_leaves
            for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
                if (i < NTAPS) begin : g_mul
                    logic signed [PW-1:0] prod;
                    assign prod = $signed(taps[i*DW +: DW]) * $signed(wgts[i*WW +: WW]);
                    assign v[i] = {{(SW-PW){prod[PW-1]}}, prod};
                end else begin : g_pad
                    assign v[i] = '0;
                end
            end
        end else begin : g_add
            for (genvar j = 0; j < (LEAVES >> l); j++) begin : g_node
                assign v[j] = g_lvl[l-1].v[2*j] + g_lvl[l-1].v[2*j+1];
            end
        end
    end

    assign sum = g_lvl[LEV].v[0];

endmodule

// File: rtl/rc3_psum_row.sv
module rc3_psum_row #(
    parameter int AW    = 24,
    parameter int SW    = 20,
    parameter int MAX_W = 16,
    localparam int CW   = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_col,
    input  logic [SW-1:0] add_val,
    input  logic          seed_en,
    input  logic [AW-1:0] seed_val,
    input  logic [CW-1:0] rd_col,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] mem [MAX_W];
    logic [AW-1:0] base;
    logic [AW-1:0] add_ext;

    // Start value: seed on the first channel, stored partial sum otherwise
    assign base    = seed_en ? seed_val : mem[wr_col];
    assign add_ext = {{(AW-SW){add_val[SW-1]}}, add_val};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_col] <= base + add_ext;
        end
    end

    assign rd_data = mem[rd_col];

    // R9
    wr_col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_col) < MAX_W));

endmodule

// File: rtl/rowconv3_engine.sv
module rowconv3_engine
    import rowconv3_pkg::*;
#(
    parameter int DW    = 8,
    parameter int WW    = 8,
    parameter int AW    = 24,
    parameter int MAX_W = 16,
    localparam int CW   = (MAX_W > 1) ? $clog2(MAX_W) : 1,
    localparam int NW   = $clog2(MAX_W + 1),
    localparam int SW   = DW + WW + $clog2(NTAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [MAX_W*DW-1:0] in_row,
    input  logic [NTAPS*WW-1:0] in_wgt,
    input  logic                in_compute,
    input  logic                in_first,
    input  logic                in_last,
    input  logic [NW-1:0]       cfg_width,
    input  logic                cfg_bias_en,
    input  logic [AW-1:0]       cfg_bias,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [AW-1:0]       out_data,
    output logic                out_last
);

    eng_state_t          st, st_nx;
    logic [CW-1:0]       col_q;
    logic [NW-1:0]       wid_q;
    logic                first_q, last_q, bias_en_q;
    logic [AW-1:0]       bias_q;
    logic [NTAPS*WW-1:0] wgt_q;
    logic                accept;
    logic                col_end;
    logic [NTAPS*DW-1:0] taps;
    logic [SW-1:0]       dot;
    logic [AW-1:0]       rd_data;

    assign accept  = in_valid && in_ready;
    assign col_end = (NW'(col_q) == wid_q - NW'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (accept && in_compute) st_nx = ST_SWEEP;
            ST_SWEEP: if (col_end) st_nx = last_q ? ST_EMIT : ST_IDLE;
            ST_EMIT:  if (out_ready && col_end) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Column counter shared by sweep and emission
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE:  col_q <= '0;
                ST_SWEEP: col_q <= col_end ? '0 : col_q + CW'(1);
                ST_EMIT:  if (out_ready) col_q <= col_end ? '0 : col_q + CW'(1);
                default:  col_q <= '0;
            endcase
        end
    end

    // Per-row settings captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wid_q     <= NW'(1);
            first_q   <= 1'b0;
            last_q    <= 1'b0;
            bias_en_q <= 1'b0;
            bias_q    <= '0;
            wgt_q     <= '0;
        end else if (accept && in_compute) begin
            wid_q     <= cfg_width;
            first_q   <= in_first;
            last_q    <= in_last;
            bias_en_q <= cfg_bias_en;
            bias_q    <= cfg_bias;
            wgt_q     <= in_wgt;
        end
    end

    // Output process
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (st)
            ST_IDLE:  in_ready = 1'b1;
            ST_SWEEP: ;
            ST_EMIT: begin
                out_valid = 1'b1;
                out_last  = col_end;
            end
            default: ;
        endcase
    end
    assign out_data = rd_data;

    rc3_row_banks #(.DW(DW), .MAX_W(MAX_W)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_row   (in_row),
        .rd_col   (col_q),
        .rd_width (wid_q),
        .taps     (taps)
    );

    rc3_mac9 #(.DW(DW), .WW(WW)) u_mac (
        .taps (taps),
        .wgts (wgt_q),
        .sum  (dot)
    );

    rc3_psum_row #(.AW(AW), .SW(SW), .MAX_W(MAX_W)) u_psum (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st == ST_SWEEP),
        .wr_col   (col_q),
        .add_val  (dot),
        .seed_en  (first_q),
        .seed_val (bias_en_q ? bias_q : '0),
        .rd_col   (col_q),
        .rd_data  (rd_data)
    );

    // R1
    ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R7
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWEEP && !col_end) |=> (st == ST_SWEEP && col_q == $past(col_q) + CW'(1)));

    // R6
    emit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWEEP && col_end && last_q) |=> (out_valid && col_q == '0));

    // R9
    cfg_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (cfg_width != '0 && int'(cfg_width) <= MAX_W));

endmodule

// File: tb/rowconv3_engine_bench.sv
`timescale 1ns/1ps
module rowconv3_engine_bench;

    localparam int DW = 8, WW = 8, AW = 24, MAX_W = 8;
    localparam int NW = $clog2(MAX_W + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [MAX_W*DW-1:0] in_row = '0;
    logic [9*WW-1:0]     in_wgt = '0;
    logic                in_compute = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [NW-1:0]       cfg_width = NW'(1);
    logic                cfg_bias_en = 1'b0;
    logic [AW-1:0]       cfg_bias = '0;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic [AW-1:0]       out_data;
    logic                out_last;

    int n_chk = 0, n_err = 0;
    int hist [3][MAX_W];
    int acc  [MAX_W];

    always #4 clk = ~clk;

    rowconv3_engine #(.DW(DW), .WW(WW), .AW(AW), .MAX_W(MAX_W)) u_rowconv3_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_wgt(in_wgt), .in_compute(in_compute),
        .in_first(in_first), .in_last(in_last), .cfg_width(cfg_width),
        .cfg_bias_en(cfg_bias_en), .cfg_bias(cfg_bias), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int gen(input int s);
        int h;
        h = (s * 1103 + 12345) % 65521;
        if (h < 0) h = -h;
        return (h % 256) - 128;
    endfunction

    function automatic int tap(input int r, input int x, input int w);
        if (x < 0 || x >= w) return 0;
        return hist[r][x];
    endfunction

    task automatic collect(input int w);
        int idx = 0, tick = 0, held = 0;
        bit stall = 0;
        while (idx < w && tick < 2000) begin
            out_ready = (tick % 3 != 1);
            if (stall) chk(out_valid && int'($signed(out_data)) == held,
                           "R8 hold under backpressure", int'($signed(out_data)), held);
            if (out_valid && out_ready) begin
                chk(int'($signed(out_data)) == acc[idx], "R4/R5 column value",
                    int'($signed(out_data)), acc[idx]);
                chk(out_last == (idx == w - 1), "R6 out_last position", int'(out_last),
                    int'(idx == w - 1));
                idx++;
                stall = 0;
            end else if (out_valid) begin
                stall = 1;
                held  = int'($signed(out_data));
            end else begin
                stall = 0;
            end
            tick++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(idx == w, "R6 beat count", idx, w);
        chk(!out_valid && in_ready, "R6 return to IDLE", int'(out_valid), 0);
    endtask

    task automatic push(input int w, input int seed, input bit comp, input bit first,
                        input bit last, input bit ben, input int bias);
        int v [MAX_W];
        int wt [9];
        int busy = 0;
        for (int j = 0; j < MAX_W; j++) v[j] = gen(seed * 16 + j);
        for (int k = 0; k < 9; k++) wt[k] = gen(seed * 7 + 100 + k);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        for (int j = 0; j < MAX_W; j++) in_row[j*DW +: DW] = DW'(v[j]);
        for (int k = 0; k < 9; k++) in_wgt[k*WW +: WW] = WW'(wt[k]);
        in_compute = comp; in_first = first; in_last = last;
        cfg_width = NW'(w); cfg_bias_en = ben; cfg_bias = AW'(bias);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        // R10: scramble the latched inputs while the engine works
        in_wgt = ~in_wgt; cfg_width = NW'((w % MAX_W) + 1);
        cfg_bias = cfg_bias + AW'(777); cfg_bias_en = ~ben; in_first = ~first; in_last = ~last;
        // R3 model: newest row at the bottom
        for (int j = 0; j < MAX_W; j++) begin
            hist[0][j] = hist[1][j]; hist[1][j] = hist[2][j]; hist[2][j] = v[j];
        end
        if (comp) begin
            for (int x = 0; x < w; x++) begin
                int s = 0;
                for (int r = 0; r < 3; r++)
                    for (int c = 0; c < 3; c++)
                        s += wt[3*r+c] * tap(r, x + c - 1, w);
                acc[x] = (first ? (ben ? bias : 0) : acc[x]) + s;
            end
            while (!in_ready && !out_valid && busy < 1000) begin
                busy++;
                @(negedge clk);
            end
            chk(busy == w, "R7 sweep length", busy, w);
            if (last) collect(w);
            else chk(in_ready && !out_valid, "R6 no output without last", int'(out_valid), 0);
        end else begin
            chk(in_ready && !out_valid, "R2 prime row stays IDLE", int'(in_ready), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R7 watchdog act=%0d exp=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int sd = 1;
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid, "R1 state during reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // Single channel, every width, rotating window over several output rows
        for (int w = 1; w <= MAX_W; w++) begin
            push(w, sd++, 0, 0, 0, 0, 0);
            push(w, sd++, 0, 0, 0, 0, 0);
            for (int k = 0; k < 3; k++)
                push(w, sd++, 1, 1, 1, (w + k) % 2, w * 13 - 50);
        end

        // Multi-channel accumulation with prime rows in between (R2, R5)
        for (int m = 0; m < 4; m++) begin
            int w = (m == 0) ? 3 : (m == 1) ? MAX_W : (m == 2) ? 1 : 5;
            for (int ch = 0; ch < 3; ch++) begin
                push(w, sd++, 0, 0, 0, 0, 0);
                push(w, sd++, 0, 0, 0, 0, 0);
                push(w, sd++, 1, ch == 0, ch == 2, m % 2, -1000 + m);
            end
        end

        // Two channels sharing a rotated window: no prime rows between them
        push(6, sd++, 0, 0, 0, 0, 0);
        push(6, sd++, 1, 1, 0, 1, 4321);
        push(6, sd++, 1, 0, 1, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule